// File: doc/BRIEF.md
# Streaming Packet Header Parser

The block examines a packet that arrives one byte per beat, with a valid qualifier and an end-of-packet flag. It walks a fixed graph of header states: link layer first, then an optional single label-switching entry or an IPv4 header, then an optional TCP or UDP header. It copies the main fields of each header into output registers. Each header type has its own validity flag, and that flag rises only after every byte of the header has arrived. At the end, one pulse reports whether the packet was accepted or rejected, and on acceptance the byte position where the payload starts.

The input is always ready, so there is no backpressure. Idle cycles between beats are allowed. Bytes that arrive after the verdict do not change anything, up to and including the final beat of the packet. The next valid beat after a final beat starts a new packet. Payload bytes are never stored.

Top module: `hdr_parser`

## Requirements
- R1: After reset, and on the first beat of every packet, all five validity flags read 0. Flag bits are: bit 0 Ethernet, bit 1 label entry, bit 2 IPv4, bit 3 TCP, bit 4 UDP. Parsing of the 14-byte Ethernet header starts with no condition checked.
- R2: The type field is bytes 12 and 13 of the packet, big endian. When Ethernet completes, a type of 0x8847 leads to the label state and 0x0800 leads to the IPv4 state. Any other type leads to reject, with only the Ethernet flag set.
- R3: A label entry is 4 bytes. Its 20-bit label is the first 20 bits, and its bottom-of-stack flag is bit 0 of the entry's third byte. When that flag is 1 the packet is accepted with payload offset 18. When it is 0 the packet is rejected.
- R4: The IPv4 header length in 32-bit words is the low nibble of the header's first byte. A value below 5 rejects. Otherwise the header, including any option bytes, spans length×4 bytes, and the IPv4 flag is set only when the last option byte has arrived.
- R5: The IPv4 protocol byte is byte 9 of that header. Value 6 leads to TCP, value 17 leads to UDP, and any other value accepts with the payload offset placed right after the IPv4 header.
- R6: The TCP header has 20 fixed bytes. Its data offset is the high nibble of the header's byte 12. A value below 5 rejects; otherwise option bytes are skipped up to offset×4, and the packet is then accepted.
- R7: The UDP header is 8 bytes. Once it completes, the packet is always accepted, with the payload offset just past it.
- R8: If the final beat arrives before the header in progress is complete, or exactly at the end of a header that leads on to another header, the packet is rejected. Flags stay set only for headers that completed.
- R9: The done output is high for exactly one cycle per packet, in the cycle after the deciding beat. Accept and payload offset hold until the next done. On a reject, the offset reads 0.
- R10: Extracted fields are loaded big endian from their byte positions: MAC addresses from bytes 0..11, IPv4 source address from IPv4 bytes 12..15, UDP destination port from UDP bytes 2..3.
- R11: Beats after the verdict and idle cycles (valid low) change no output. A packet carrying trailing payload gets the same verdict and offset as the same headers with no payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Byte beat present |
| inData | input | 8 | Packet byte |
| inLast | input | 1 | Final byte of the packet |
| done | output | 1 | One-cycle verdict pulse |
| accept | output | 1 | Verdict: 1 accepted, 0 rejected |
| payloadOffset | output | POS_W | Payload start byte on accept, 0 on reject |
| hdrValid | output | 5 | Per-header validity flags |
| ethDst | output | 48 | Destination MAC |
| ethSrc | output | 48 | Source MAC |
| ethType | output | 16 | Link-layer type |
| mplsLabel | output | 20 | Label value |
| mplsBos | output | 1 | Bottom-of-stack flag |
| ipIhl | output | 4 | IPv4 header length in words |
| ipProto | output | 8 | IPv4 protocol |
| ipSrc | output | 32 | IPv4 source address |
| ipDst | output | 32 | IPv4 destination address |
| tcpSrcPort | output | 16 | TCP source port |
| tcpDstPort | output | 16 | TCP destination port |
| tcpDataOff | output | 4 | TCP data offset |
| udpSrcPort | output | 16 | UDP source port |
| udpDstPort | output | 16 | UDP destination port |
| udpLen | output | 16 | UDP length |

## Verification
A wrong state or a wrong byte count inside a header shows up in the pulse for the same packet. The done pulse either arrives one beat early or late, which moves the payload offset, or it does not arrive at all and the done count goes wrong. A misplaced field index gives a wrong extracted field or a wrong branch at the next header boundary, and that is visible at the latest by the end of the packet. Validity flags left over from an earlier packet show up on the next packet whose headers form a shorter chain.

// File: rtl/hdr_parser_pkg.sv
package hdr_parser_pkg;

  typedef enum logic [3:0] {
    ST_START, ST_ETH, ST_MPLS, ST_IP, ST_IPOPT,
    ST_TCP, ST_TCPOPT, ST_UDP, ST_ACCEPT, ST_REJECT
  } parseState_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ETH, SEL_MPLS, SEL_IP, SEL_TCP, SEL_UDP
  } hdrSel_t;

  localparam int HV_W   = 5;
  localparam int VB_ETH = 0;
  localparam int VB_MPLS = 1;
  localparam int VB_IP  = 2;
  localparam int VB_TCP = 3;
  localparam int VB_UDP = 4;

  localparam logic [5:0] ETH_LAST  = 6'd13;
  localparam logic [5:0] MPLS_LAST = 6'd3;
  localparam logic [5:0] IP_LAST   = 6'd19;
  localparam logic [5:0] TCP_LAST  = 6'd19;
  localparam logic [5:0] UDP_LAST  = 6'd7;

  localparam logic [15:0] TYPE_LABEL = 16'h8847;
  localparam logic [15:0] TYPE_IPV4  = 16'h0800;
  localparam logic [7:0]  PROTO_TCP  = 8'd6;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;

  typedef struct packed {
    logic            beat;
    logic            first;
    hdrSel_t         sel;
    logic [5:0]      idx;
    logic [HV_W-1:0] setValid;
    logic            done;
    logic            accept;
  } ctlStrobe_t;

endpackage

// File: rtl/hp_ctrl.sv
module hp_ctrl
  import hdr_parser_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLast,
  input  logic [7:0] inData,
  input  logic [7:0] ethTypeHi,
  input  logic       mplsBos,
  input  logic [3:0] ipIhl,
  input  logic [7:0] ipProto,
  input  logic [3:0] tcpDataOff,
  output ctlStrobe_t strobe
);

  parseState_t state, stateN, effState;
  logic [5:0]  cnt, cntN, effCnt;
  logic [5:0]  skipLast, skipLastN;
  logic        inPacket;
  logic        inHeader;

  function automatic parseState_t protoNext(input logic [7:0] p);
    if (p == PROTO_TCP)      return ST_TCP;
    else if (p == PROTO_UDP) return ST_UDP;
    else                     return ST_ACCEPT;
  endfunction

  always_comb begin
    effState = inPacket ? state : ST_ETH;
    effCnt   = inPacket ? cnt : 6'd0;
    inHeader = (effState != ST_ACCEPT) && (effState != ST_REJECT) && (effState != ST_START);
    stateN    = state;
    cntN      = cnt;
    skipLastN = skipLast;
    strobe    = '0;
    if (inValid) begin
      strobe.beat  = 1'b1;
      strobe.first = !inPacket;
      strobe.idx   = effCnt;
      stateN       = effState;
      cntN         = effCnt + 6'd1;
      unique case (effState)
        ST_ETH: begin
          strobe.sel = SEL_ETH;
          if (effCnt == ETH_LAST) begin
            strobe.setValid[VB_ETH] = 1'b1;
            cntN = '0;
            if ({ethTypeHi, inData} == TYPE_LABEL)     stateN = ST_MPLS;
            else if ({ethTypeHi, inData} == TYPE_IPV4) stateN = ST_IP;
            else                                       stateN = ST_REJECT;
          end
        end
        ST_MPLS: begin
          strobe.sel = SEL_MPLS;
          if (effCnt == MPLS_LAST) begin
            strobe.setValid[VB_MPLS] = 1'b1;
            stateN = mplsBos ? ST_ACCEPT : ST_REJECT;
          end
        end
        ST_IP: begin
          strobe.sel = SEL_IP;
          if (effCnt == IP_LAST) begin
            cntN = '0;
            if (ipIhl < 4'd5) stateN = ST_REJECT;
            else if (ipIhl == 4'd5) begin
              strobe.setValid[VB_IP] = 1'b1;
              stateN = protoNext(ipProto);
            end else begin
              stateN    = ST_IPOPT;
              skipLastN = {ipIhl - 4'd6, 2'b11};
            end
          end
        end
        ST_IPOPT: begin
          if (effCnt == skipLast) begin
            strobe.setValid[VB_IP] = 1'b1;
            cntN   = '0;
            stateN = protoNext(ipProto);
          end
        end
        ST_TCP: begin
          strobe.sel = SEL_TCP;
          if (effCnt == TCP_LAST) begin
            cntN = '0;
            if (tcpDataOff < 4'd5) stateN = ST_REJECT;
            else if (tcpDataOff == 4'd5) begin
              strobe.setValid[VB_TCP] = 1'b1;
              stateN = ST_ACCEPT;
            end else begin
              stateN    = ST_TCPOPT;
              skipLastN = {tcpDataOff - 4'd6, 2'b11};
            end
          end
        end
        ST_TCPOPT: begin
          if (effCnt == skipLast) begin
            strobe.setValid[VB_TCP] = 1'b1;
            stateN = ST_ACCEPT;
          end
        end
        ST_UDP: begin
          strobe.sel = SEL_UDP;
          if (effCnt == UDP_LAST) begin
            strobe.setValid[VB_UDP] = 1'b1;
            stateN = ST_ACCEPT;
          end
        end
        default: cntN = cnt;
      endcase
      if (inHeader) begin
        if (stateN == ST_ACCEPT || stateN == ST_REJECT) begin
          strobe.done   = 1'b1;
          strobe.accept = (stateN == ST_ACCEPT);
        end else if (inLast) begin
          stateN        = ST_REJECT;
          strobe.done   = 1'b1;
          strobe.accept = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_START;
      cnt      <= '0;
      skipLast <= '0;
      inPacket <= 1'b0;
    end else begin
      state    <= stateN;
      cnt      <= cntN;
      skipLast <= skipLastN;
      if (inValid) inPacket <= !inLast;
    end
  end

endmodule

// File: rtl/hp_datapath.sv
module hp_datapath
  import hdr_parser_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [7:0]       inData,
  output logic             done,
  output logic             accept,
  output logic [POS_W-1:0] payloadOffset,
  output logic [HV_W-1:0]  hdrValid,
  output logic [47:0]      ethDst,
  output logic [47:0]      ethSrc,
  output logic [15:0]      ethType,
  output logic [19:0]      mplsLabel,
  output logic             mplsBos,
  output logic [3:0]       ipIhl,
  output logic [7:0]       ipProto,
  output logic [31:0]      ipSrc,
  output logic [31:0]      ipDst,
  output logic [15:0]      tcpSrcPort,
  output logic [15:0]      tcpDstPort,
  output logic [3:0]       tcpDataOff,
  output logic [15:0]      udpSrcPort,
  output logic [15:0]      udpDstPort,
  output logic [15:0]      udpLen
);

  logic [POS_W-1:0] pos, curIdx;
  logic [5:0]       i;

  assign curIdx = strobe.first ? '0 : pos;
  assign i      = strobe.idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos           <= '0;
      done          <= 1'b0;
      accept        <= 1'b0;
      payloadOffset <= '0;
      hdrValid      <= '0;
    end else begin
      done <= strobe.done;
      if (strobe.beat) begin
        pos      <= curIdx + 1'b1;
        hdrValid <= (strobe.first ? '0 : hdrValid) | strobe.setValid;
      end
      if (strobe.done) begin
        accept        <= strobe.accept;
        payloadOffset <= strobe.accept ? curIdx + 1'b1 : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.beat) begin
      unique case (strobe.sel)
        SEL_ETH: begin
          if (i < 6'd6)       ethDst  <= {ethDst[39:0], inData};
          else if (i < 6'd12) ethSrc  <= {ethSrc[39:0], inData};
          else                ethType <= {ethType[7:0], inData};
        end
        SEL_MPLS: begin
          if (i == 6'd0)      mplsLabel[19:12] <= inData;
          else if (i == 6'd1) mplsLabel[11:4]  <= inData;
          else if (i == 6'd2) begin
            mplsLabel[3:0] <= inData[7:4];
            mplsBos        <= inData[0];
          end
        end
        SEL_IP: begin
          if (i == 6'd0)      ipIhl   <= inData[3:0];
          else if (i == 6'd9) ipProto <= inData;
          else if (i >= 6'd12 && i < 6'd16) ipSrc <= {ipSrc[23:0], inData};
          else if (i >= 6'd16) ipDst <= {ipDst[23:0], inData};
        end
        SEL_TCP: begin
          if (i < 6'd2)        tcpSrcPort <= {tcpSrcPort[7:0], inData};
          else if (i < 6'd4)   tcpDstPort <= {tcpDstPort[7:0], inData};
          else if (i == 6'd12) tcpDataOff <= inData[7:4];
        end
        SEL_UDP: begin
          if (i < 6'd2)      udpSrcPort <= {udpSrcPort[7:0], inData};
          else if (i < 6'd4) udpDstPort <= {udpDstPort[7:0], inData};
          else if (i < 6'd6) udpLen     <= {udpLen[7:0], inData};
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/hdr_parser.sv
module hdr_parser
  import hdr_parser_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [7:0]       inData,
  input  logic             inLast,
  output logic             done,
  output logic             accept,
  output logic [POS_W-1:0] payloadOffset,
  output logic [4:0]       hdrValid,
  output logic [47:0]      ethDst,
  output logic [47:0]      ethSrc,
  output logic [15:0]      ethType,
  output logic [19:0]      mplsLabel,
  output logic             mplsBos,
  output logic [3:0]       ipIhl,
  output logic [7:0]       ipProto,
  output logic [31:0]      ipSrc,
  output logic [31:0]      ipDst,
  output logic [15:0]      tcpSrcPort,
  output logic [15:0]      tcpDstPort,
  output logic [3:0]       tcpDataOff,
  output logic [15:0]      udpSrcPort,
  output logic [15:0]      udpDstPort,
  output logic [15:0]      udpLen
);

  ctlStrobe_t strobe;

  hp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast), .inData(inData),
    .ethTypeHi(ethType[7:0]), .mplsBos(mplsBos), .ipIhl(ipIhl), .ipProto(ipProto),
    .tcpDataOff(tcpDataOff), .strobe(strobe)
  );

  hp_datapath #(.POS_W(POS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .done(done), .accept(accept), .payloadOffset(payloadOffset), .hdrValid(hdrValid),
    .ethDst(ethDst), .ethSrc(ethSrc), .ethType(ethType),
    .mplsLabel(mplsLabel), .mplsBos(mplsBos),
    .ipIhl(ipIhl), .ipProto(ipProto), .ipSrc(ipSrc), .ipDst(ipDst),
    .tcpSrcPort(tcpSrcPort), .tcpDstPort(tcpDstPort), .tcpDataOff(tcpDataOff),
    .udpSrcPort(udpSrcPort), .udpDstPort(udpDstPort), .udpLen(udpLen)
  );

endmodule

// File: rtl/hp_checker.sv
module hp_checker #(
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inLast,
  input logic             done,
  input logic             accept,
  input logic [POS_W-1:0] payloadOffset,
  input logic [4:0]       hdrValid
);

  assert_accept_has_eth_R2: assert property (@(posedge clk) disable iff (!rstN)
    done && accept |-> hdrValid[0]);

  assert_label_excludes_ip_R2: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid[1] |-> !hdrValid[2]);

  assert_one_transport_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(hdrValid[3] && hdrValid[4]));

  assert_transport_needs_ip_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid[3] || hdrValid[4]) |-> hdrValid[2]);

  assert_label_offset_R3: assert property (@(posedge clk) disable iff (!rstN)
    done && accept && hdrValid[1] |-> payloadOffset == POS_W'(18));

  assert_udp_offset_R7: assert property (@(posedge clk) disable iff (!rstN)
    done && accept && hdrValid[4] |-> payloadOffset >= POS_W'(42));

  assert_reject_offset_R9: assert property (@(posedge clk) disable iff (!rstN)
    done && !accept |-> payloadOffset == '0);

  assert_done_after_beat_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(inValid));

  logic unusedLast;
  assign unusedLast = inLast;

endmodule

bind hdr_parser hp_checker #(.POS_W(POS_W)) u_chk (.*);

// File: tb/test_hdr_parser.sv
module test_hdr_parser;

  localparam int POS_W = 16;

  logic clk = 0, rstN = 0, inValid = 0, inLast = 0;
  logic [7:0] inData = 0;
  logic done, accept;
  logic [POS_W-1:0] payloadOffset;
  logic [4:0] hdrValid;
  logic [47:0] ethDst, ethSrc;
  logic [15:0] ethType, tcpSrcPort, tcpDstPort, udpSrcPort, udpDstPort, udpLen;
  logic [19:0] mplsLabel;
  logic mplsBos;
  logic [3:0] ipIhl, tcpDataOff;
  logic [7:0] ipProto;
  logic [31:0] ipSrc, ipDst;

  hdr_parser #(.POS_W(POS_W)) i_hdr_parser (.*);

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  int doneCnt = 0;
  bit gotAcc;
  int gotOff;
  logic [4:0] gotVb;
  logic [47:0] gotDst;
  logic [15:0] gotType, gotUdpDst;
  logic [19:0] gotLabel;
  logic [31:0] gotSrcIp;

  always @(negedge clk) begin
    if (rstN && done) begin
      doneCnt++;
      gotAcc = accept; gotOff = int'(payloadOffset); gotVb = hdrValid;
      gotDst = ethDst; gotType = ethType; gotUdpDst = udpDstPort;
      gotLabel = mplsLabel; gotSrcIp = ipSrc;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] p[$], output bit acc, output int off,
                                output logic [4:0] vb, output string rule);
    int n, s, hl, dl;
    n = p.size(); acc = 0; off = 0; vb = 0; rule = "R8";
    if (n < 14) return;
    vb[0] = 1;
    if ({p[12], p[13]} == 16'h8847) begin
      if (n < 18) return;
      vb[1] = 1; rule = "R3";
      if (p[16][0]) begin acc = 1; off = 18; end
      return;
    end
    if ({p[12], p[13]} != 16'h0800) begin rule = "R2"; return; end
    if (n < 34) return;
    if (p[14][3:0] < 5) begin rule = "R4"; return; end
    hl = int'(p[14][3:0]) * 4;
    if (n < 14 + hl) return;
    vb[2] = 1; s = 14 + hl;
    if (p[23] == 8'd6) begin
      if (n < s + 20) return;
      rule = "R6";
      if (p[s+12][7:4] < 5) return;
      dl = int'(p[s+12][7:4]) * 4;
      if (n < s + dl) begin rule = "R8"; return; end
      vb[3] = 1; acc = 1; off = s + dl;
    end else if (p[23] == 8'd17) begin
      if (n < s + 8) return;
      vb[4] = 1; rule = "R7"; acc = 1; off = s + 8;
    end else begin
      rule = (hl > 20) ? "R4" : "R5"; acc = 1; off = s;
    end
  endfunction

  function automatic void build(output logic [7:0] p[$], input logic [15:0] et, input bit bos,
                                input logic [3:0] ihl, input logic [7:0] proto,
                                input logic [3:0] doff, input int extra);
    int b;
    p = {};
    for (int k = 0; k < 12; k++) p.push_back(8'($urandom));
    p.push_back(et[15:8]); p.push_back(et[7:0]);
    if (et == 16'h8847) begin
      for (int k = 0; k < 4; k++) p.push_back(8'($urandom));
      p[16][0] = bos;
    end else if (et == 16'h0800) begin
      b = p.size();
      for (int k = 0; k < 20; k++) p.push_back(8'($urandom));
      p[b] = {4'h4, ihl}; p[b+9] = proto;
      for (int k = 20; k < int'(ihl) * 4; k++) p.push_back(8'($urandom));
      if (proto == 8'd6) begin
        b = p.size();
        for (int k = 0; k < 20; k++) p.push_back(8'($urandom));
        p[b+12] = {doff, 4'h0};
        for (int k = 20; k < int'(doff) * 4; k++) p.push_back(8'($urandom));
      end else if (proto == 8'd17) begin
        for (int k = 0; k < 8; k++) p.push_back(8'($urandom));
      end
    end
    for (int k = 0; k < extra; k++) p.push_back(8'($urandom));
  endfunction

  task automatic runPkt(input logic [7:0] p[$], input int gapPct);
    bit acc; int off; logic [4:0] vb; string rule; int n;
    doneCnt = 0;
    n = p.size();
    for (int k = 0; k < n; k++) begin
      while (int'($urandom_range(0, 99)) < gapPct) begin
        inValid = 0; inLast = 0; @(negedge clk);
      end
      inValid = 1; inData = p[k]; inLast = (k == n - 1);
      @(negedge clk);
    end
    inValid = 0; inLast = 0;
    #2;
    model(p, acc, off, vb, rule);
    check(doneCnt == 1, "R9", "done pulses", doneCnt, 1);
    check(gotAcc == acc, rule, "verdict", gotAcc, acc);
    check(gotOff == off, rule, "payload offset", gotOff, off);
    check(gotVb == vb, "R8", "valid flags", gotVb, vb);
    if (vb[0]) begin
      check(gotDst == {p[0], p[1], p[2], p[3], p[4], p[5]}, "R10", "dst mac", gotDst, {p[0], p[1], p[2], p[3], p[4], p[5]});
      check(gotType == {p[12], p[13]}, "R10", "type", gotType, {p[12], p[13]});
    end
    if (vb[1]) check(gotLabel == {p[14], p[15], p[16][7:4]}, "R10", "label", gotLabel, {p[14], p[15], p[16][7:4]});
    if (vb[2]) check(gotSrcIp == {p[26], p[27], p[28], p[29]}, "R10", "ip src", gotSrcIp, {p[26], p[27], p[28], p[29]});
    if (vb[4]) check(gotUdpDst == {p[off-6], p[off-5]}, "R10", "udp dst", gotUdpDst, {p[off-6], p[off-5]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] p[$];
    int offA;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(done == 0, "R1", "done after reset", done, 0);
    check(hdrValid == 0, "R1", "flags after reset", hdrValid, 0);
    check(payloadOffset == 0, "R9", "offset after reset", payloadOffset, 0);

    build(p, 16'h0800, 1, 4'd5, 8'd17, 4'd5, 0); runPkt(p, 0);
    check(gotOff == 42 && gotAcc, "R7", "udp exact end", gotOff, 42);
    build(p, 16'h1234, 1, 4'd5, 8'd17, 4'd5, 4); runPkt(p, 0);
    check(gotVb == 5'b00001, "R1", "flags cleared on new packet", gotVb, 5'b00001);
    build(p, 16'h0800, 1, 4'd5, 8'd17, 4'd5, 0); p = p[0:13]; runPkt(p, 0);
    check(!gotAcc && gotVb == 5'b00001, "R8", "ends at link header", gotVb, 5'b00001);
    build(p, 16'h0800, 1, 4'd4, 8'd6, 4'd5, 6); runPkt(p, 10);
    check(!gotAcc, "R4", "short ihl", gotAcc, 0);
    build(p, 16'h0800, 1, 4'd15, 8'd6, 4'd15, 0); runPkt(p, 0);
    check(gotAcc && gotOff == 134, "R6", "max options", gotOff, 134);
    build(p, 16'h0800, 1, 4'd5, 8'd6, 4'd3, 3); runPkt(p, 0);
    check(!gotAcc && gotVb == 5'b00101, "R6", "short data offset", gotVb, 5'b00101);
    build(p, 16'h8847, 0, 4'd5, 8'd6, 4'd5, 3); runPkt(p, 0);
    check(!gotAcc, "R3", "label not bottom", gotAcc, 0);
    build(p, 16'h8847, 1, 4'd5, 8'd6, 4'd5, 0); runPkt(p, 0);
    check(gotAcc && gotOff == 18, "R3", "label bottom", gotOff, 18);
    build(p, 16'h0800, 1, 4'd7, 8'd50, 4'd5, 2); runPkt(p, 0);
    check(gotAcc && gotOff == 42, "R5", "other protocol", gotOff, 42);
    p = {8'h55}; runPkt(p, 0);
    check(!gotAcc && gotVb == 0, "R8", "single byte", gotVb, 0);
    build(p, 16'h0800, 1, 4'd5, 8'd17, 4'd5, 0); runPkt(p, 0); offA = gotOff;
    for (int k = 0; k < 30; k++) p.push_back(8'h08);
    runPkt(p, 40);
    check(gotOff == offA && doneCnt == 1, "R11", "trailing payload ignored", gotOff, offA);

    for (int n = 0; n < 250; n++) begin
      logic [15:0] et; logic [3:0] ihl, doff; logic [7:0] pr; int r, newLen;
      r = int'($urandom_range(0, 9));
      et = (r < 2) ? 16'h8847 : (r < 8) ? 16'h0800 : 16'($urandom);
      ihl = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'd5;
      doff = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'd5;
      r = int'($urandom_range(0, 9));
      pr = (r < 4) ? 8'd6 : (r < 8) ? 8'd17 : 8'($urandom);
      build(p, et, $urandom_range(0, 3) != 0, ihl, pr, doff, int'($urandom_range(0, 8)));
      if ($urandom_range(0, 9) < 3) begin
        newLen = int'($urandom_range(1, p.size()));
        while (p.size() > newLen) void'(p.pop_back());
      end
      runPkt(p, 20);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule